// File: doc/BRIEF.md
# Result Latency and Iterator Occupancy Scoreboard

This block keeps timing state for an in-order issue stage. Every issued instruction carries a class code, a precision bit and an optional destination register tag. The block loads a per-register countdown with the result latency of that class and precision. The register's ready bit stays low until the countdown expires. Three iterative resources also have their own occupancy countdowns: the integer multiply/divide iterator, the floating-point multiply iterator and the floating-point divide/square-root iterator. The block raises a busy flag for each one while it is held.

The issue logic reads the ready vector to find operand hazards, and reads the busy flags and a short issue-hold flag to find structural hazards. Result latency and unit occupancy are kept apart. A 32-bit integer multiply, for example, frees the multiplier after 3 cycles, but its result is not ready until 5 cycles after issue. No arithmetic is done here.

Top module: `latency_scoreboard`

## Requirements
- R1: While reset is applied and after it is released with no issue, every `reg_ready` bit is 1 and `imd_busy`, `fmul_busy`, `fds_busy` and `hold_issue` are 0.
- R2: An issue with `iss_wr`=1 drives `reg_ready[iss_tag]` low in the issue cycle itself. An issue with `iss_wr`=0 leaves every ready bit unchanged.
- R3: A register's latency L is the number of rising edges after the issue edge before its ready bit reads 1. For the single-cycle classes, L is: code 0 simple ALU = 1, code 1 load = 2, code 2 store = 1, code 3 branch = 3, code 7 move to HI/LO = 3, code 8 move from HI/LO = 1, code 9 FP add/negate/compare/abs/move/convert = 4, code 13 transfer to/from FP = 2. Unused codes 14 and 15 behave as latency 1. For these classes `iss_wide` has no effect.
- R4: Code 4 integer divide has latency 36 and holds `imd_busy` high for 36 cycles when `iss_wide`=0. With `iss_wide`=1 both values are 68.
- R5: Code 5 integer multiply or multiply-add has latency 5 with 3 busy cycles on `imd_busy` when `iss_wide`=0. With `iss_wide`=1 it has latency 9 with 8 busy cycles.
- R6: Code 6 three-operand multiply with `iss_wide`=0 has latency 2, raises no busy flag, and holds `hold_issue` high for the 2 cycles after issue, during which nothing issues. With `iss_wide`=1 it has latency 9 with 8 cycles on `imd_busy`.
- R7: Code 10 FP multiply has latency 4 with 1 cycle on `fmul_busy` when `iss_wide`=0. With `iss_wide`=1 it has latency 5 with 2 busy cycles.
- R8: Code 11 FP divide/square root has latency and `fds_busy` occupancy of 21 when `iss_wide`=0 and 36 when `iss_wide`=1. Code 12 reciprocal square root uses 38 and 68.
- R9: A busy flag reads 1 in exactly the N cycles after the issue edge, where N is the occupancy count. An instruction that needs a unit never issues while that unit's flag is 1.
- R10: A new write issue to a tag whose countdown is still running reloads it, so the later instruction's latency decides when the bit returns to 1.
- R11: Countdowns of different registers run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_class | input | 4 | Instruction class code |
| iss_wide | input | 1 | 1 = 64-bit integer or double-precision FP |
| iss_wr | input | 1 | Instruction writes a destination register |
| iss_tag | input | TAG_W | Destination register tag |
| reg_ready | output | NUM_REGS | Per-register result-available flags |
| imd_busy | output | 1 | Integer multiply/divide iterator occupied |
| fmul_busy | output | 1 | FP multiply iterator occupied |
| fds_busy | output | 1 | FP divide/square-root iterator occupied |
| hold_issue | output | 1 | Extra stall after a 32-bit three-operand multiply |

## Verification
The ready bit for a destination tag drops combinationally in the issue cycle. It returns exactly L rising edges after the issue edge, and a busy or hold flag is high for exactly N cycles starting after the issue edge. Inputs are driven on the falling edge, and outputs are sampled 1 ns after each falling edge. From that, each scenario counts the sample at which the ready bit first reads 1 and the number of samples with each flag high, then compares both counts with the values in the requirements. The reload and independence cases look at fixed sample indices worked out from the same rule.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  localparam int CNT_W = 7;

  typedef enum logic [3:0] {
    OP_ALU    = 4'd0,
    OP_LOAD   = 4'd1,
    OP_STORE  = 4'd2,
    OP_BRANCH = 4'd3,
    OP_IDIV   = 4'd4,
    OP_IMUL   = 4'd5,
    OP_IMUL3  = 4'd6,
    OP_TOHL   = 4'd7,
    OP_FROMHL = 4'd8,
    OP_FADD   = 4'd9,
    OP_FMUL   = 4'd10,
    OP_FDIVSQ = 4'd11,
    OP_FRSQ   = 4'd12,
    OP_XFER   = 4'd13
  } op_class_e;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'd0,
    UNIT_IMD  = 2'd1,
    UNIT_FMUL = 2'd2,
    UNIT_FDS  = 2'd3
  } iter_unit_e;

  localparam int NUM_UNITS = 3;
  localparam int STALL_CYC = 2;

  typedef struct packed {
    logic [CNT_W-1:0] lat;
    iter_unit_e       unit;
    logic [CNT_W-1:0] occ;
    logic             stall;
  } op_timing_t;

endpackage

// File: rtl/lsb_decode.sv
module lsb_decode
  import lsb_pkg::*;
(
  input  logic [3:0] cls,
  input  logic       wide,
  output op_timing_t tim
);

  function automatic logic [CNT_W-1:0] pick(input logic w, input int narrow, input int broad);
    pick = w ? CNT_W'(broad) : CNT_W'(narrow);
  endfunction

  always_comb begin
    tim.lat   = CNT_W'(1);
    tim.unit  = UNIT_NONE;
    tim.occ   = '0;
    tim.stall = 1'b0;
    case (cls)
      OP_ALU, OP_STORE, OP_FROMHL: tim.lat = CNT_W'(1);
      OP_LOAD, OP_XFER:            tim.lat = CNT_W'(2);
      OP_BRANCH, OP_TOHL:          tim.lat = CNT_W'(3);
      OP_FADD:                     tim.lat = CNT_W'(4);
      OP_IDIV: begin
        tim.lat  = pick(wide, 36, 68);
        tim.occ  = pick(wide, 36, 68);
        tim.unit = UNIT_IMD;
      end
      OP_IMUL: begin
        tim.lat  = pick(wide, 5, 9);
        tim.occ  = pick(wide, 3, 8);
        tim.unit = UNIT_IMD;
      end
      OP_IMUL3: begin
        if (wide) begin
          tim.lat  = CNT_W'(9);
          tim.occ  = CNT_W'(8);
          tim.unit = UNIT_IMD;
        end else begin
          tim.lat   = CNT_W'(2);
          tim.stall = 1'b1;
        end
      end
      OP_FMUL: begin
        tim.lat  = pick(wide, 4, 5);
        tim.occ  = pick(wide, 1, 2);
        tim.unit = UNIT_FMUL;
      end
      OP_FDIVSQ: begin
        tim.lat  = pick(wide, 21, 36);
        tim.occ  = pick(wide, 21, 36);
        tim.unit = UNIT_FDS;
      end
      OP_FRSQ: begin
        tim.lat  = pick(wide, 38, 68);
        tim.occ  = pick(wide, 38, 68);
        tim.unit = UNIT_FDS;
      end
      default: tim.lat = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/lsb_countdown.sv
module lsb_countdown #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle = (cnt_q == '0);

endmodule

// File: rtl/latency_scoreboard.sv
module latency_scoreboard
  import lsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  input  logic [3:0]          iss_class,
  input  logic                iss_wide,
  input  logic                iss_wr,
  input  logic [TAG_W-1:0]    iss_tag,
  output logic [NUM_REGS-1:0] reg_ready,
  output logic                imd_busy,
  output logic                fmul_busy,
  output logic                fds_busy,
  output logic                hold_issue
);

  localparam int HOLD_W = $clog2(STALL_CYC + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe_q[1];

  op_timing_t tim;

  lsb_decode u_dec (
    .cls  (iss_class),
    .wide (iss_wide),
    .tim  (tim)
  );

  // per-register result countdowns, loaded with latency minus one
  logic [NUM_REGS-1:0] reg_idle;
  logic [NUM_REGS-1:0] reg_hit;
  logic [CNT_W-1:0]    reg_load_val;

  assign reg_load_val = tim.lat - CNT_W'(1);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign reg_hit[r] = iss_valid && iss_wr && (iss_tag == TAG_W'(r));

    lsb_countdown #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .load     (reg_hit[r]),
      .load_val (reg_load_val),
      .idle     (reg_idle[r])
    );

    assign reg_ready[r] = reg_idle[r] && !reg_hit[r];
  end

  // iterative unit occupancy countdowns
  logic [NUM_UNITS-1:0] unit_idle;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic unit_load;
    assign unit_load = iss_valid && (tim.unit == iter_unit_e'(u + 1));

    lsb_countdown #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .load     (unit_load),
      .load_val (tim.occ),
      .idle     (unit_idle[u])
    );
  end

  assign imd_busy  = !unit_idle[0];
  assign fmul_busy = !unit_idle[1];
  assign fds_busy  = !unit_idle[2];

  // extra stall after a narrow three-operand multiply
  logic hold_idle;

  lsb_countdown #(.W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (iss_valid && tim.stall),
    .load_val (HOLD_W'(STALL_CYC)),
    .idle     (hold_idle)
  );

  assign hold_issue = !hold_idle;

endmodule

// File: rtl/latency_scoreboard_chk.sv
module latency_scoreboard_chk #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic [3:0]          iss_class,
  input logic                iss_wide,
  input logic                iss_wr,
  input logic [TAG_W-1:0]    iss_tag,
  input logic [NUM_REGS-1:0] reg_ready,
  input logic                imd_busy,
  input logic                fmul_busy,
  input logic                fds_busy,
  input logic                hold_issue
);

  logic uses_imd;
  assign uses_imd = iss_valid && ((iss_class == 4'd4) || (iss_class == 4'd5) ||
                                  (iss_class == 4'd6 && iss_wide));

  AST_ALU_NEXT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_wr && iss_class == 4'd0) |=>
      (reg_ready[$past(iss_tag)] || (iss_valid && iss_wr && iss_tag == $past(iss_tag)))); // R3

  AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_wr && iss_class == 4'd1) |=> !reg_ready[$past(iss_tag)]); // R3

  AST_DIV_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == 4'd4) |=> imd_busy); // R4

  AST_FDS_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_class == 4'd11 || iss_class == 4'd12)) |=> fds_busy); // R8

  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    uses_imd |-> !imd_busy); // R9

  AST_HOLD_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == 4'd6 && !iss_wide) |=> hold_issue); // R6

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_issue |-> !iss_valid); // R6

  AST_FMUL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == 4'd10 && !iss_wide) |=> ##1 !fmul_busy || iss_valid); // R7

endmodule

bind latency_scoreboard latency_scoreboard_chk #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_class  (iss_class),
  .iss_wide   (iss_wide),
  .iss_wr     (iss_wr),
  .iss_tag    (iss_tag),
  .reg_ready  (reg_ready),
  .imd_busy   (imd_busy),
  .fmul_busy  (fmul_busy),
  .fds_busy   (fds_busy),
  .hold_issue (hold_issue)
);

// File: tb/latency_scoreboard_test.sv
`timescale 1ns/1ps
module latency_scoreboard_test;

  localparam int NREG = 32;
  localparam int TW   = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            iss_valid;
  logic [3:0]      iss_class;
  logic            iss_wide;
  logic            iss_wr;
  logic [TW-1:0]   iss_tag;
  logic [NREG-1:0] reg_ready;
  logic            imd_busy, fmul_busy, fds_busy, hold_issue;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  latency_scoreboard #(.NUM_REGS(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_wide(iss_wide), .iss_wr(iss_wr), .iss_tag(iss_tag), .reg_ready(reg_ready),
    .imd_busy(imd_busy), .fmul_busy(fmul_busy), .fds_busy(fds_busy), .hold_issue(hold_issue)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_class = 4'd0; iss_wide = 1'b0; iss_wr = 1'b0; iss_tag = '0;
  endtask

  // issue one op, then count cycles until ready and cycles each flag is high
  task automatic run_op(input string req, input int cls, input bit wide, input int tag,
                        input int exp_lat, input int unit, input int exp_occ, input int exp_hold);
    int lat_seen;
    int occ [4];
    int hold_cnt;
    lat_seen = 0; hold_cnt = 0;
    for (int k = 0; k < 4; k++) occ[k] = 0;
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'(cls); iss_wide = wide; iss_wr = 1'b1; iss_tag = TW'(tag);
    #1;
    check("R2", "ready in issue cycle", int'(reg_ready[tag]), 0);
    @(posedge clk);
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      idle_inputs();
      #1;
      if (reg_ready[tag] && lat_seen == 0) lat_seen = n;
      if (imd_busy)   occ[1]++;
      if (fmul_busy)  occ[2]++;
      if (fds_busy)   occ[3]++;
      if (hold_issue) hold_cnt++;
    end
    check(req, $sformatf("latency class %0d wide %0d", cls, wide), lat_seen, exp_lat);
    for (int k = 1; k < 4; k++)
      check(req, $sformatf("busy cycles unit %0d class %0d wide %0d", k, cls, wide),
            occ[k], (k == unit) ? exp_occ : 0);
    check(req, $sformatf("hold cycles class %0d", cls), hold_cnt, exp_hold);
  endtask

  task automatic test_reset();
    check("R1", "ready vector after reset", int'(&reg_ready), 1);
    check("R1", "busy/hold after reset", int'({imd_busy, fmul_busy, fds_busy, hold_issue}), 0);
  endtask

  task automatic test_no_write();
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd2; iss_wr = 1'b0; iss_tag = TW'(3);
    #1;
    check("R2", "no-write issue cycle ready", int'(&reg_ready), 1);
    @(negedge clk);
    idle_inputs();
    #1;
    check("R2", "no-write next cycle ready", int'(&reg_ready), 1);
  endtask

  task automatic test_reload();
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd4; iss_wide = 1'b0; iss_wr = 1'b1; iss_tag = TW'(5);
    @(negedge clk); idle_inputs();
    @(negedge clk);
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd0; iss_wr = 1'b1; iss_tag = TW'(5);
    @(negedge clk); idle_inputs();
    #1;
    check("R10", "reload by short op", int'(reg_ready[5]), 1);
    for (int n = 0; n < 80 && imd_busy; n++) @(negedge clk);
    #1;
    check("R10", "divider free later", int'(imd_busy), 0);
  endtask

  task automatic test_independent();
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd1; iss_wr = 1'b1; iss_tag = TW'(1);
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd3; iss_wr = 1'b1; iss_tag = TW'(2);
    @(negedge clk); idle_inputs(); #1;
    check("R11", "load tag ready after 2", int'(reg_ready[1]), 1);
    check("R11", "branch tag busy at 1", int'(reg_ready[2]), 0);
    @(negedge clk); #1;
    check("R11", "branch tag busy at 2", int'(reg_ready[2]), 0);
    @(negedge clk); #1;
    check("R11", "branch tag ready at 3", int'(reg_ready[2]), 1);
    check("R11", "load tag stays ready", int'(reg_ready[1]), 1);
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    test_reset();
    test_no_write();
    run_op("R3", 0,  1'b0, 7,  1, 0, 0, 0);
    run_op("R3", 1,  1'b0, 8,  2, 0, 0, 0);
    run_op("R3", 2,  1'b1, 9,  1, 0, 0, 0);
    run_op("R3", 3,  1'b0, 10, 3, 0, 0, 0);
    run_op("R3", 7,  1'b0, 11, 3, 0, 0, 0);
    run_op("R3", 8,  1'b0, 12, 1, 0, 0, 0);
    run_op("R3", 9,  1'b1, 13, 4, 0, 0, 0);
    run_op("R3", 13, 1'b0, 14, 2, 0, 0, 0);
    run_op("R3", 15, 1'b0, 15, 1, 0, 0, 0);
    run_op("R4", 4,  1'b0, 16, 36, 1, 36, 0);
    run_op("R4", 4,  1'b1, 17, 68, 1, 68, 0);
    run_op("R5", 5,  1'b0, 18, 5, 1, 3, 0);
    run_op("R5", 5,  1'b1, 19, 9, 1, 8, 0);
    run_op("R6", 6,  1'b0, 20, 2, 0, 0, 2);
    run_op("R6", 6,  1'b1, 21, 9, 1, 8, 0);
    run_op("R7", 10, 1'b0, 22, 4, 2, 1, 0);
    run_op("R7", 10, 1'b1, 23, 5, 2, 2, 0);
    run_op("R8", 11, 1'b0, 24, 21, 3, 21, 0);
    run_op("R8", 11, 1'b1, 25, 36, 3, 36, 0);
    run_op("R8", 12, 1'b0, 26, 38, 3, 38, 0);
    run_op("R9", 12, 1'b1, 27, 68, 3, 68, 0);
    test_reload();
    test_independent();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule